// File: doc/BRIEF.md
# Multiply/Divide Issue Occupancy Tracker

This block sits beside an in-order issue stage. It tracks when a new integer divide or multiply may be sent to the execution side. It models only time. The arithmetic happens elsewhere, and this block records how long a divide holds the single non-pipelined divider and how long a wide multiply holds the multiplier issue port. It also gives a countdown to the moment the hi/lo result pair has taken its last pending write, so later writers of hi/lo can wait for it.

Each divide has a lead-in phase, then a busy phase, then a tail. The busy phase does not start on the issue cycle; it opens a fixed number of cycles later. Because of this, a second divide may be accepted while the first one is still in its tail, provided the second busy phase begins no earlier than the cycle after the first one ends. The issue stage presents a request. It counts as accepted in any cycle where the matching ready output is high, and the effect is seen from the next cycle on.

Top module: `muldiv_occupancy`

## Requirements
- R1: A synchronous reset, applied at any time, leaves div_ready=1, mul_ready=1, div_busy=0 and hilo_wait=0 in the cycle after the reset edge.
- R2: A narrow divide (div_wide=0) accepted in cycle t raises div_busy in cycles t+4 through t+35 and leaves it low in t+1 through t+3, unless an earlier divide's window covers those cycles.
- R3: A wide divide (div_wide=1) accepted in cycle t raises div_busy in cycles t+4 through t+67.
- R4: After a divide is accepted in cycle t, div_ready is low until its window is within 4 cycles of its end. It is high again in cycle t+32 for a narrow divide and in cycle t+64 for a wide one. A divide is accepted only when div_req and div_ready are both high.
- R5: A divide accepted in the first cycle that div_ready is high again gets a busy window that starts exactly one cycle after the previous window ends, so div_busy stays high with no gap.
- R6: A div_req presented while div_ready is low is ignored: the div_ready release cycle, div_busy and hilo_wait all stay as they would have been without it.
- R7: An accepted wide multiply (mul_wide=1) drops mul_ready for exactly the following cycle. An accepted narrow multiply leaves mul_ready high.
- R8: A mul_req presented while mul_ready is low is ignored, even a wide one: mul_ready is high again in the cycle after.
- R9: hilo_wait counts the cycles left until the last pending hi/lo write. An operation accepted in cycle t that writes hi/lo in cycle t+D shows hilo_wait = D-1 in cycle t+1, then counts down by one each cycle to 0. D is 40 for a narrow divide, 72 for a wide divide, 8 for a wide multiply and 7 for a narrow multiply.
- R10: A divide and a multiply accepted in the same cycle both take effect. hilo_wait always shows the largest remaining count among all pending writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| div_req | input | 1 | Divide issue request |
| div_wide | input | 1 | Divide is 64-bit (1) or 32-bit (0) |
| mul_req | input | 1 | Multiply issue request |
| mul_wide | input | 1 | Multiply is 64-bit (1) or 32-bit (0) |
| div_ready | output | 1 | A divide may be accepted this cycle |
| div_busy | output | 1 | The divider's busy window is active |
| mul_ready | output | 1 | A multiply may be accepted this cycle |
| hilo_wait | output | 7 | Cycles left until the last pending hi/lo write |

## Verification
The assertions assume that requests are only acted on when the matching ready output is high. The block enforces this itself, so a request held high while ready is low is legal input and counts as nothing. The stimulus therefore drives div_req and mul_req freely, including during blocked cycles, and sets the width bits at random. It also places directed requests on the exact cycle that ready returns, on the cycle right after a wide multiply, and in one cycle together for both units. Reset is asserted only on clock-aligned boundaries and with requests low, and this includes once in the middle of an active divide.

// File: rtl/muldiv_occ_pkg.sv
package muldiv_occ_pkg;

  // One cycle's accepted issue events, handed to the hi/lo timer.
  typedef struct packed {
    logic div_go;
    logic div_wide;
    logic mul_go;
    logic mul_wide;
  } issue_evt_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/muldiv_div_window.sv
// Divider occupancy. rem counts down to the end of the latest busy window.
// prev_rem keeps the tail of the window before it while a follow-on divide
// is still in its lead-in. LEAD must be at least 1.
module muldiv_div_window #(
  parameter int LEAD       = 4,
  parameter int NARROW_OCC = 32,
  parameter int WIDE_OCC   = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic wide,
  output logic ready,
  output logic busy
);

  localparam int REM_MAX = LEAD + WIDE_OCC;
  localparam int RW      = $clog2(REM_MAX + 1);
  localparam int LW      = $clog2(LEAD + 1);
  localparam logic [RW-1:0] NARROW_LOAD = RW'(LEAD + NARROW_OCC - 1);
  localparam logic [RW-1:0] WIDE_LOAD   = RW'(LEAD + WIDE_OCC - 1);
  localparam logic [RW-1:0] READY_AT    = RW'(LEAD);

  logic [RW-1:0] rem_q, rem_n, prev_q, prev_n;
  logic [LW-1:0] lead_q, lead_n;
  logic          ready_q, busy_q;

  function automatic logic [RW-1:0] dec_r(input logic [RW-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  always_comb begin
    if (fire) begin
      rem_n  = wide ? WIDE_LOAD : NARROW_LOAD;
      prev_n = dec_r(rem_q);
      lead_n = LW'(LEAD - 1);
    end else begin
      rem_n  = dec_r(rem_q);
      prev_n = dec_r(prev_q);
      lead_n = (lead_q == '0) ? lead_q : lead_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      prev_q  <= '0;
      lead_q  <= '0;
      ready_q <= 1'b1;
      busy_q  <= 1'b0;
    end else begin
      rem_q   <= rem_n;
      prev_q  <= prev_n;
      lead_q  <= lead_n;
      ready_q <= (rem_n <= READY_AT);
      busy_q  <= ((lead_n == '0) && (rem_n != '0)) || (prev_n != '0);
    end
  end

  assign ready = ready_q;
  assign busy  = busy_q;

endmodule

// File: rtl/muldiv_mul_port.sv
// Multiplier issue port. A wide multiply holds the port for WIDE_HOLD
// extra cycles after its issue cycle.
module muldiv_mul_port #(
  parameter int WIDE_HOLD = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic wide,
  output logic ready
);

  localparam int HW = $clog2(WIDE_HOLD + 1);

  logic [HW-1:0] hold_q, hold_n;
  logic          ready_q;

  always_comb begin
    if (fire && wide)       hold_n = HW'(WIDE_HOLD);
    else if (hold_q != '0)  hold_n = hold_q - 1'b1;
    else                    hold_n = hold_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      ready_q <= 1'b1;
    end else begin
      hold_q  <= hold_n;
      ready_q <= (hold_n == '0);
    end
  end

  assign ready = ready_q;

endmodule

// File: rtl/muldiv_hilo_timer.sv
// Countdown to the last pending hi/lo write; the largest remaining count wins.
module muldiv_hilo_timer
  import muldiv_occ_pkg::*;
#(
  parameter int CW        = 7,
  parameter int DIV_N_WR  = 40,
  parameter int DIV_W_WR  = 72,
  parameter int MUL_N_WR  = 7,
  parameter int MUL_W_WR  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  issue_evt_t    evt,
  output logic [CW-1:0] wait_cnt
);

  logic [CW-1:0] cnt_q, dec_v, div_v, mul_v, pick_v;

  always_comb begin
    dec_v = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
    div_v = '0;
    mul_v = '0;
    if (evt.div_go) div_v = evt.div_wide ? CW'(DIV_W_WR - 1) : CW'(DIV_N_WR - 1);
    if (evt.mul_go) mul_v = evt.mul_wide ? CW'(MUL_W_WR - 1) : CW'(MUL_N_WR - 1);
    pick_v = dec_v;
    if (div_v > pick_v) pick_v = div_v;
    if (mul_v > pick_v) pick_v = mul_v;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= pick_v;
  end

  assign wait_cnt = cnt_q;

endmodule

// File: rtl/muldiv_occupancy.sv
module muldiv_occupancy
  import muldiv_occ_pkg::*;
#(
  parameter int LEAD       = 4,
  parameter int NARROW_OCC = 32,
  parameter int WIDE_OCC   = 64,
  parameter int HILO_TAIL  = 4,
  parameter int MUL_WR     = 7,
  parameter int MUL_HOLD   = 1,
  parameter int HW         = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          div_req,
  input  logic          div_wide,
  input  logic          mul_req,
  input  logic          mul_wide,
  output logic          div_ready,
  output logic          div_busy,
  output logic          mul_ready,
  output logic [HW-1:0] hilo_wait
);

  localparam int DIV_N_WR = LEAD + NARROW_OCC + HILO_TAIL;
  localparam int DIV_W_WR = LEAD + WIDE_OCC + HILO_TAIL;
  localparam int MUL_N_WR = MUL_WR;
  localparam int MUL_W_WR = MUL_WR + MUL_HOLD;

  logic       div_fire, mul_fire;
  issue_evt_t evt;

  assign div_fire = div_req && div_ready;
  assign mul_fire = mul_req && mul_ready;

  always_comb begin
    evt.div_go   = div_fire;
    evt.div_wide = div_wide;
    evt.mul_go   = mul_fire;
    evt.mul_wide = mul_wide;
  end

  muldiv_div_window #(
    .LEAD(LEAD), .NARROW_OCC(NARROW_OCC), .WIDE_OCC(WIDE_OCC)
  ) u_div (
    .clk(clk), .rst(rst), .fire(div_fire), .wide(div_wide),
    .ready(div_ready), .busy(div_busy)
  );

  muldiv_mul_port #(.WIDE_HOLD(MUL_HOLD)) u_mul (
    .clk(clk), .rst(rst), .fire(mul_fire), .wide(mul_wide), .ready(mul_ready)
  );

  muldiv_hilo_timer #(
    .CW(HW), .DIV_N_WR(DIV_N_WR), .DIV_W_WR(DIV_W_WR),
    .MUL_N_WR(MUL_N_WR), .MUL_W_WR(MUL_W_WR)
  ) u_hilo (
    .clk(clk), .rst(rst), .evt(evt), .wait_cnt(hilo_wait)
  );

endmodule

// File: rtl/muldiv_occupancy_chk.sv
module muldiv_occupancy_chk #(
  parameter int LEAD = 4,
  parameter int HW   = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          div_req,
  input logic          mul_req,
  input logic          mul_wide,
  input logic          div_ready,
  input logic          div_busy,
  input logic          mul_ready,
  input logic [HW-1:0] hilo_wait
);

  logic [7:0] age_q;

  always_ff @(posedge clk) begin
    if (rst)                        age_q <= 8'hFF;
    else if (div_req && div_ready)  age_q <= 8'd1;
    else if (age_q != 8'hFF)        age_q <= age_q + 8'd1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (div_ready && mul_ready && !div_busy && hilo_wait == '0));

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(div_busy) |-> (age_q == 8'(LEAD)));

  // R4
  div_block_chk: assert property (@(posedge clk) disable iff (rst)
    (div_req && div_ready) |=> !div_ready);

  // R7
  mul_block_chk: assert property (@(posedge clk) disable iff (rst)
    (mul_req && mul_ready && mul_wide) |=> !mul_ready);

  // R8
  mul_release_chk: assert property (@(posedge clk) disable iff (rst)
    !mul_ready |=> mul_ready);

  // R9
  hilo_count_chk: assert property (@(posedge clk) disable iff (rst)
    (hilo_wait != '0 && !(div_req && div_ready) && !(mul_req && mul_ready))
      |=> (hilo_wait == $past(hilo_wait) - 1'b1));

endmodule

bind muldiv_occupancy muldiv_occupancy_chk #(.LEAD(LEAD), .HW(HW)) u_chk (
  .clk(clk), .rst(rst), .div_req(div_req), .mul_req(mul_req),
  .mul_wide(mul_wide), .div_ready(div_ready), .div_busy(div_busy),
  .mul_ready(mul_ready), .hilo_wait(hilo_wait)
);

// File: tb/muldiv_occupancy_tb.sv
module muldiv_occupancy_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NONE = -100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       div_req = 1'b0, div_wide = 1'b0, mul_req = 1'b0, mul_wide = 1'b0;
  logic       div_ready, div_busy, mul_ready;
  logic [6:0] hilo_wait;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model, in absolute cycle numbers
  int cyc = 0;
  int w1_s, w1_e, w0_s, w0_e;
  bit w1_wide;
  int mul64_at, hilo_dl;
  bit ign_div, ign_mul, both_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  muldiv_occupancy u_dut (
    .clk(clk), .rst(rst), .div_req(div_req), .div_wide(div_wide),
    .mul_req(mul_req), .mul_wide(mul_wide), .div_ready(div_ready),
    .div_busy(div_busy), .mul_ready(mul_ready), .hilo_wait(hilo_wait)
  );

  function automatic void model_reset();
    w1_s = NONE; w1_e = NONE; w0_s = NONE; w0_e = NONE; w1_wide = 0;
    mul64_at = NONE; hilo_dl = NONE;
    ign_div = 0; ign_mul = 0; both_prev = 0;
  endfunction

  function automatic bit exp_busy(input int c);
    return (c >= w1_s && c < w1_e) || (c >= w0_s && c < w0_e);
  endfunction
  function automatic bit exp_dready(input int c);
    return (c + 4 >= w1_e);
  endfunction
  function automatic bit exp_mready(input int c);
    return (c != mul64_at + 1);
  endfunction
  function automatic int exp_hilo(input int c);
    return (hilo_dl > c) ? hilo_dl - c : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic check_now();
    string bt;
    if (w0_e != NONE && cyc >= w0_s && cyc < w1_s + 2) bt = "R5";
    else bt = w1_wide ? "R3" : "R2";
    chk(bt, int'(div_busy), int'(exp_busy(cyc)));
    chk(ign_div ? "R6" : "R4", int'(div_ready), int'(exp_dready(cyc)));
    chk(ign_mul ? "R8" : "R7", int'(mul_ready), int'(exp_mready(cyc)));
    chk(both_prev ? "R10" : "R9", int'(hilo_wait), exp_hilo(cyc));
  endtask

  // called at a negedge: check, drive, update model, advance one cycle
  task automatic step(input bit dr, input bit dw, input bit mr, input bit mw);
    bit dacc, macc;
    check_now();
    div_req = dr; div_wide = dw; mul_req = mr; mul_wide = mw;
    dacc = dr && exp_dready(cyc);
    macc = mr && exp_mready(cyc);
    ign_div = dr && !dacc;
    ign_mul = mr && !macc;
    both_prev = dacc && macc;
    if (dacc) begin
      w0_s = w1_s; w0_e = w1_e;
      w1_s = cyc + 4; w1_e = cyc + 4 + (dw ? 64 : 32); w1_wide = dw;
      if (w1_e + 4 > hilo_dl) hilo_dl = w1_e + 4;
    end
    if (macc) begin
      if (cyc + (mw ? 8 : 7) > hilo_dl) hilo_dl = cyc + (mw ? 8 : 7);
      if (mw) mul64_at = cyc;
    end
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic do_reset();
    div_req = 0; mul_req = 0; div_wide = 0; mul_wide = 0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    model_reset();
    // R1 reset state
    chk("R1", int'(div_ready), 1);
    chk("R1", int'(mul_ready), 1);
    chk("R1", int'(div_busy), 0);
    chk("R1", int'(hilo_wait), 0);
    rst = 1'b0;
  endtask

  initial begin
    process::self().srandom(32'd5123);
    model_reset();
    @(negedge clk);
    do_reset();
    cyc = 0;
    // directed: narrow divide, then blocked request (R6), then back-to-back (R5)
    step(1, 0, 0, 0);
    idle(9);
    step(1, 1, 0, 0);               // ignored, not ready
    idle(21);                       // reaches cycle 32
    step(1, 0, 0, 0);               // accepted exactly at release
    idle(7);
    step(0, 0, 1, 1);               // wide multiply (R7)
    step(0, 0, 1, 1);               // blocked multiply (R8)
    step(0, 0, 1, 0);               // narrow multiply
    idle(21);
    step(1, 1, 1, 0);               // divide and multiply together (R10)
    idle(80);
    // random phase
    for (int i = 0; i < 4000; i++)
      step(($urandom % 8) == 0, $urandom % 2, ($urandom % 3) == 0, $urandom % 2);
    // reset in the middle of a divide (R1)
    step(1, 1, 0, 0);
    idle(10);
    do_reset();
    for (int i = 0; i < 300; i++)
      step(($urandom % 6) == 0, $urandom % 2, ($urandom % 2) == 0, $urandom % 2);
    check_now();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule